// File: doc/BRIEF.md
# Paged Program Window Address Translator

This block turns a 16-bit CPU address into a 20-bit extended address in a 1 MB space. A 6-bit page register, written and read through one register port, selects which 16 KB page shows through a fixed program window at CPU addresses 0x8000 to 0xBFFF. The two other 16 KB regions that flash occupies are tied to hard-wired pages. The lowest 16 KB region belongs to registers, RAM and EEPROM and is only flagged.

The forward path is combinational from the CPU address and the registered page value. Its outputs are the upper six extended bits (the page), the lower fourteen bits (the offset within the page) and three region indicators.

A second, independent combinational port takes a linear 20-bit address and returns the page number and the matching window address. Software can use it to check image placement against what the forward path produces.

Top module: `pgwin_xlate`

## Requirements
- R1: After reset the page register reads back 0x00.
- R2: A write strobe with data V changes the page register at the next clock edge. The register port reads V from then on, and not before that edge. With no write strobe the register holds its value.
- R3: For CPU addresses 0x8000–0xBFFF, `win_hit_o` is 1 and `ext_hi_o` equals the page register.
- R4: For CPU addresses 0x4000–0x7FFF, `ext_hi_o` is 0x3E and `fixed_hit_o` is 1, whatever the page register holds.
- R5: For CPU addresses 0xC000–0xFFFF, `ext_hi_o` is 0x3F and `fixed_hit_o` is 1, whatever the page register holds.
- R6: For CPU addresses 0x0000–0x3FFF, `low_rgn_o` is 1, `ext_hi_o` is 0x00 and `win_hit_o` is 0.
- R7: `ext_lo_o` always equals CPU address bits 13..0. Exactly one of `low_rgn_o`, `fixed_hit_o`, `win_hit_o` is 1 for any address.
- R8: On the reverse port, `rev_page_o` = linear / 0x4000 and `rev_win_o` = (linear mod 0x4000) + 0x8000. For example, 0xE1003 gives page 0x38 and window address 0x9003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_we_i | input | 1 | Page register write strobe |
| page_wdata_i | input | 6 | Page register write data |
| page_rdata_o | output | 6 | Page register read-back |
| cpu_addr_i | input | 16 | CPU address |
| ext_hi_o | output | 6 | Extended address bits 19..14 (page) |
| ext_lo_o | output | 14 | Address bits 13..0 (page offset) |
| win_hit_o | output | 1 | Address lies in the program window |
| fixed_hit_o | output | 1 | Address lies in a hard-wired flash region |
| low_rgn_o | output | 1 | Address lies in the register/RAM/EEPROM region |
| lin_addr_i | input | 20 | Linear address for reverse conversion |
| rev_page_o | output | 6 | Page number from the linear address |
| rev_win_o | output | 16 | Window address from the linear address |

## Verification
The bench probes the region edges at 0x3FFF/0x4000, 0x7FFF/0x8000 and 0xBFFF/0xC000. A decoder off by one there would map a window byte to a fixed page, or leak the page register into a fixed region. It samples the read-back in the cycle of the write and in the next cycle, so a register that updated early or one cycle late is caught. It loads distinctive page values before touching the fixed regions and the low region, so a design that let the page register steer them would show a wrong upper address. Reverse conversions at 0x00000, 0xFFFFF and mid-range values expose a window address missing its 0x8000 offset or a page taken from the wrong bits.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam int unsigned PAGE_W = 6;
  localparam int unsigned OFS_W  = 14;
  localparam int unsigned CPU_AW = 16;
  localparam int unsigned EXT_AW = PAGE_W + OFS_W;
  localparam int unsigned SEL_W  = CPU_AW - OFS_W;

  typedef enum logic [1:0] {
    RGN_LOW   = 2'b00,
    RGN_FIXLO = 2'b01,
    RGN_WIN   = 2'b10,
    RGN_FIXHI = 2'b11
  } rgn_e;
endpackage

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg #(
  parameter int unsigned PAGE_W = 6,
  parameter logic [PAGE_W-1:0] RST_PAGE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= RST_PAGE;
    else if (we_i) page_q <= wdata_i;
  end

  assign page_o = page_q;

  p_page_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> page_o == $past(wdata_i));
  p_page_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(page_o));
endmodule

// File: rtl/pgwin_rgn_dec.sv
module pgwin_rgn_dec
  import pgwin_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned OFSW = 14
) (
  input  logic [AW-1:0] addr_i,
  output rgn_e          rgn_o,
  output logic          low_o,
  output logic          fixed_o,
  output logic          win_o
);
  localparam int unsigned SW = AW - OFSW;

  logic [SW-1:0] sel;
  assign sel   = addr_i[AW-1:OFSW];
  assign rgn_o = rgn_e'(sel);

  always_comb begin
    low_o   = 1'b0;
    fixed_o = 1'b0;
    win_o   = 1'b0;
    unique case (rgn_o)
      RGN_LOW:             low_o   = 1'b1;
      RGN_WIN:             win_o   = 1'b1;
      RGN_FIXLO, RGN_FIXHI: fixed_o = 1'b1;
      default:             low_o   = 1'b1;
    endcase
  end
endmodule

// File: rtl/pgwin_fwd_map.sv
module pgwin_fwd_map
  import pgwin_pkg::*;
#(
  parameter int unsigned PAGE_W = 6,
  parameter logic [PAGE_W-1:0] FIX_LO_PAGE = 6'h3E,
  parameter logic [PAGE_W-1:0] FIX_HI_PAGE = 6'h3F
) (
  input  rgn_e              rgn_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PAGE_W-1:0] hi_o
);
  always_comb begin
    unique case (rgn_i)
      RGN_WIN:   hi_o = page_i;
      RGN_FIXLO: hi_o = FIX_LO_PAGE;
      RGN_FIXHI: hi_o = FIX_HI_PAGE;
      default:   hi_o = '0;
    endcase
  end
endmodule

// File: rtl/pgwin_rev_map.sv
module pgwin_rev_map #(
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned OFS_W  = 14,
  parameter int unsigned CPU_AW = 16,
  parameter logic [CPU_AW-OFS_W-1:0] WIN_SEL = 2'b10
) (
  input  logic [PAGE_W+OFS_W-1:0] lin_i,
  output logic [PAGE_W-1:0]       page_o,
  output logic [CPU_AW-1:0]       win_o
);
  localparam int unsigned EAW = PAGE_W + OFS_W;

  // divide/mod by the page size reduce to a bit split
  assign page_o = lin_i[EAW-1:OFS_W];
  assign win_o  = {WIN_SEL, lin_i[OFS_W-1:0]};
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate
  import pgwin_pkg::*;
#(
  parameter logic [PAGE_W-1:0] FIX_LO_PAGE = 6'h3E,
  parameter logic [PAGE_W-1:0] FIX_HI_PAGE = 6'h3F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_we_i,
  input  logic [PAGE_W-1:0] page_wdata_i,
  output logic [PAGE_W-1:0] page_rdata_o,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  output logic [PAGE_W-1:0] ext_hi_o,
  output logic [OFS_W-1:0]  ext_lo_o,
  output logic              win_hit_o,
  output logic              fixed_hit_o,
  output logic              low_rgn_o,
  input  logic [EXT_AW-1:0] lin_addr_i,
  output logic [PAGE_W-1:0] rev_page_o,
  output logic [CPU_AW-1:0] rev_win_o
);
  localparam logic [SEL_W-1:0] WIN_SEL = SEL_W'(RGN_WIN);

  logic [PAGE_W-1:0] page;
  rgn_e              rgn;

  pgwin_page_reg #(.PAGE_W(PAGE_W), .RST_PAGE('0)) u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (page_we_i),
    .wdata_i (page_wdata_i),
    .page_o  (page)
  );

  pgwin_rgn_dec #(.AW(CPU_AW), .OFSW(OFS_W)) u_dec (
    .addr_i  (cpu_addr_i),
    .rgn_o   (rgn),
    .low_o   (low_rgn_o),
    .fixed_o (fixed_hit_o),
    .win_o   (win_hit_o)
  );

  pgwin_fwd_map #(
    .PAGE_W(PAGE_W), .FIX_LO_PAGE(FIX_LO_PAGE), .FIX_HI_PAGE(FIX_HI_PAGE)
  ) u_fwd (
    .rgn_i  (rgn),
    .page_i (page),
    .hi_o   (ext_hi_o)
  );

  pgwin_rev_map #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .CPU_AW(CPU_AW), .WIN_SEL(WIN_SEL)
  ) u_rev (
    .lin_i  (lin_addr_i),
    .page_o (rev_page_o),
    .win_o  (rev_win_o)
  );

  assign page_rdata_o = page;
  assign ext_lo_o     = cpu_addr_i[OFS_W-1:0];

  p_win_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i >= 16'h8000 && cpu_addr_i <= 16'hBFFF) |->
      (win_hit_o && ext_hi_o == page_rdata_o));
  p_fix_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i >= 16'h4000 && cpu_addr_i <= 16'h7FFF) |->
      (fixed_hit_o && ext_hi_o == FIX_LO_PAGE));
  p_fix_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i >= 16'hC000) |-> (fixed_hit_o && ext_hi_o == FIX_HI_PAGE));
  p_low_rgn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_rgn_o |-> (!win_hit_o && ext_hi_o == '0 && cpu_addr_i < 16'h4000));
  p_one_rgn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({low_rgn_o, fixed_hit_o, win_hit_o}) == 1);
  p_rev_round_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({rev_page_o, 14'h0} + 20'(rev_win_o) - 20'h8000) == lin_addr_i);
endmodule

// File: tb/pgwin_xlate_tb.sv
module pgwin_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  wdata = '0;
  logic [5:0]  rdata;
  logic [15:0] cpu_addr = '0;
  logic [5:0]  ext_hi;
  logic [13:0] ext_lo;
  logic        win_hit, fixed_hit, low_rgn;
  logic [19:0] lin = '0;
  logic [5:0]  rev_page;
  logic [15:0] rev_win;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pgwin_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .page_we_i(we), .page_wdata_i(wdata), .page_rdata_o(rdata),
    .cpu_addr_i(cpu_addr), .ext_hi_o(ext_hi), .ext_lo_o(ext_lo),
    .win_hit_o(win_hit), .fixed_hit_o(fixed_hit), .low_rgn_o(low_rgn),
    .lin_addr_i(lin), .rev_page_o(rev_page), .rev_win_o(rev_win)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_page(input logic [5:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  // forward lookup with expected page from the requirements
  task automatic probe(input logic [15:0] a, input logic [5:0] page);
    logic [5:0] exp_hi;
    string req;
    cpu_addr = a;
    #1;
    if (a < 16'h4000)      begin exp_hi = 6'h00; req = "R6"; end
    else if (a < 16'h8000) begin exp_hi = 6'h3E; req = "R4"; end
    else if (a < 16'hC000) begin exp_hi = page;  req = "R3"; end
    else                   begin exp_hi = 6'h3F; req = "R5"; end
    chk(req, ext_hi, exp_hi);
    chk("R7 lo", ext_lo, a[13:0]);
    chk({req, " win"}, win_hit, (a >= 16'h8000 && a < 16'hC000));
    chk({req, " fix"}, fixed_hit, (a >= 16'h4000 && a < 16'h8000) || a >= 16'hC000);
    chk({req, " low"}, low_rgn, a < 16'h4000);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    chk("R1 reset page", rdata, 6'h00);
  endtask

  task automatic t_write_timing_r2();
    @(negedge clk);
    we = 1'b1; wdata = 6'h15;
    #1;
    chk("R2 not before edge", rdata, 6'h00);
    @(negedge clk);
    we = 1'b0;
    chk("R2 after edge", rdata, 6'h15);
    wdata = 6'h2A;
    @(negedge clk);
    chk("R2 hold without strobe", rdata, 6'h15);
  endtask

  task automatic t_window_r3();
    write_page(6'h20);
    probe(16'hA003, 6'h20);
    chk("R3 linear", {ext_hi, ext_lo}, 20'h82003);
    probe(16'h8000, 6'h20);
    probe(16'hBFFF, 6'h20);
    write_page(6'h38);
    probe(16'h9003, 6'h38);
    chk("R3 linear2", {ext_hi, ext_lo}, 20'hE1003);
  endtask

  task automatic t_fixed_r4_r5();
    write_page(6'h05);
    probe(16'h4000, 6'h05);
    probe(16'h7FFF, 6'h05);
    probe(16'hC000, 6'h05);
    probe(16'hFFFF, 6'h05);
  endtask

  task automatic t_low_r6();
    write_page(6'h3C);
    probe(16'h0000, 6'h3C);
    probe(16'h3FFF, 6'h3C);
    probe(16'h1234, 6'h3C);
  endtask

  task automatic t_reverse_r8();
    logic [19:0] v [4] = '{20'hE1003, 20'h82003, 20'h00000, 20'hFFFFF};
    for (int i = 0; i < 4; i++) begin
      lin = v[i];
      #1;
      chk("R8 page", rev_page, v[i] / 20'h4000);
      chk("R8 window", rev_win, 16'((v[i] % 20'h4000) + 20'h8000));
    end
  endtask

  initial begin
    #5000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_write_timing_r2();
    t_window_r3();
    t_fixed_r4_r5();
    t_low_r6();
    t_reverse_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule